// File: doc/BRIEF.md
# I2C Register-Bank Target with Port Snapshot

This block is an I2C target that runs from a fast system clock. It samples the SCL and SDA bus lines as ordinary inputs. Each line goes through a two-flop synchronizer and a three-tap majority filter before the block looks for edges. From the filtered edges it decodes Start, repeated Start and Stop, and shifts bytes in and out. It answers one 7-bit address, and two strap inputs set the low two bits of that address.

Behind the bus engine sits a bank of four 8-bit registers:

- an input view of an 8-bit pin bus, with per-bit polarity inversion;
- a latched output value;
- a polarity mask;
- a direction mask.

A command pointer chooses which register a data byte goes to or comes from. The pointer keeps its value between transactions. SDA is driven open-drain style through a single pull-low enable. The block also emits one-cycle pulses on each read acknowledge clock and on each Stop, so that a separate interrupt block can clear its state.

A host selects a register with a write transfer of the form address, then command byte. It then writes any number of data bytes, or it issues a repeated Start and reads back any number of bytes.

Top module: `i2c_regbank_target`

## Requirements
- R1: An address byte equal to {1,1,1,0,0,strap_i[1],strap_i[0],rw} (MSB first; rw=1 means read) is acknowledged. sda_drive_o is high through the ninth clock.
- R2: An address byte that does not match is not acknowledged. The block then stays silent until the next Start.
- R3: In a write transfer, the first byte after the address is a command byte. Its bits [1:0] select the register: 0 input, 1 output, 2 polarity, 3 direction. Register 3 appears on dir_o, where 1 means the pin is an input.
- R4: Every later data byte of a write transfer is acknowledged and stored in the selected register. The pointer does not advance between data bytes.
- R5: The pointer keeps its value across Stop and repeated Start. A read with no preceding command byte returns the last selected register.
- R6: A read returns the selected register, MSB first, for each byte the host clocks. After the host NACKs, SDA is released.
- R7: Writes to register 0 change no register.
- R8: Register 0 reads return the pin value XOR the polarity register, bit by bit.
- R9: Register 1 reads return the latched output value, not the pin level.
- R10: While rst_ni is low, the registers go to output 0xFF, polarity 0x00 and direction 0xFF, the pointer goes to 0, and the bus engine goes idle.
- R11: The pin value for a register-0 byte is captured on the rising SCL edge of the acknowledge clock that comes before that byte.
- R12: A Start seen in the middle of a byte discards that partial byte. The block then re-enters address reception.
- R13: rd_evt_o pulses for one cycle on each host acknowledge clock of a read. stop_o pulses for one cycle on each Stop. SDA is released during both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| strap_i | input | 2 | Low two address bits |
| pin_i | input | 8 | Pin levels read through register 0 |
| sda_drive_o | output | 1 | 1 pulls SDA low |
| out_reg_o | output | 8 | Output register value |
| dir_o | output | 8 | Direction mask, 1 = input |
| rd_evt_o | output | 1 | Pulse on each read acknowledge clock |
| stop_o | output | 1 | Pulse on each Stop |

## Verification
The internal state of this block is the pointer, the bit counter and the phase. A wrong pointer shows as the wrong register value on the very next read byte, or as a write landing on out_reg_o or dir_o when it should not. A slipped bit counter puts the acknowledge one clock early or late, so the host sees a missing ACK within the same byte. A bad snapshot shows as a register-0 byte that carries pin data from the wrong acknowledge clock, which is visible on the second byte of a read burst.

// File: rtl/i2cx_pkg.sv
package i2cx_pkg;
  localparam int unsigned DW      = 8;
  localparam int unsigned PTR_W   = 2;
  localparam int unsigned CNT_W   = $clog2(DW + 1);
  localparam logic [4:0]  ADDR_HI = 5'b11100;

  localparam logic [PTR_W-1:0] IDX_IN  = 2'd0;
  localparam logic [PTR_W-1:0] IDX_OUT = 2'd1;
  localparam logic [PTR_W-1:0] IDX_POL = 2'd2;
  localparam logic [PTR_W-1:0] IDX_DIR = 2'd3;

  localparam logic [DW-1:0] RST_OUT = '1;
  localparam logic [DW-1:0] RST_POL = '0;
  localparam logic [DW-1:0] RST_DIR = '1;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RX,
    PH_SACK,
    PH_TX,
    PH_HACK
  } phase_e;
endpackage

// File: rtl/i2cx_line_filter.sv
module i2cx_line_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned TAPS        = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CW = $clog2(TAPS + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [TAPS-1:0]        hist_q;
  logic [CW-1:0]          ones;
  logic                   vote;

  always_comb begin
    ones = '0;
    for (int i = 0; i < TAPS; i++) ones = ones + CW'(hist_q[i]);
    vote = (ones > CW'(TAPS / 2));
  end

  // idle bus level is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      hist_q <= '1;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      hist_q <= {hist_q[TAPS-2:0], sync_q[SYNC_STAGES-1]};
      line_o <= vote;
    end
  end
endmodule

// File: rtl/i2cx_reg_bank.sv
module i2cx_reg_bank
  import i2cx_pkg::*;
#(
  parameter int unsigned PIN_SYNC = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_stb_i,
  input  logic [PTR_W-1:0] sel_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             snap_i,
  input  logic [DW-1:0]    pin_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [DW-1:0]    out_o,
  output logic [DW-1:0]    dir_o
);
  logic [DW-1:0] pin_sync_q [PIN_SYNC];
  logic [DW-1:0] snap_q, pol_q, out_q, dir_q;

  for (genvar s = 0; s < PIN_SYNC; s++) begin : g_pin_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pin_sync_q[s] <= '0;
      else if (s == 0) pin_sync_q[s] <= pin_i;
      else pin_sync_q[s] <= pin_sync_q[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) snap_q <= '0;
    else if (snap_i) snap_q <= pin_sync_q[PIN_SYNC-1];
  end

  // register 0 is read-only
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= RST_OUT;
      pol_q <= RST_POL;
      dir_q <= RST_DIR;
    end else if (wr_stb_i) begin
      unique case (sel_i)
        IDX_OUT: out_q <= wr_data_i;
        IDX_POL: pol_q <= wr_data_i;
        IDX_DIR: dir_q <= wr_data_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (sel_i)
      IDX_IN:  rd_data_o = snap_q ^ pol_q;
      IDX_OUT: rd_data_o = out_q;
      IDX_POL: rd_data_o = pol_q;
      default: rd_data_o = dir_q;
    endcase
  end

  assign out_o = out_q;
  assign dir_o = dir_q;
endmodule

// File: rtl/i2cx_bus_fsm.sv
module i2cx_bus_fsm
  import i2cx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [1:0]       strap_i,
  input  logic [DW-1:0]    rd_data_i,
  output logic [PTR_W-1:0] ptr_o,
  output logic             wr_stb_o,
  output logic [DW-1:0]    wr_data_o,
  output logic             snap_o,
  output logic             sda_drive_o,
  output logic             rd_evt_o,
  output logic             stop_o
);
  phase_e        phase_q;
  logic          scl_q, sda_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DW-1:0] rx_q, tx_q;
  logic          is_addr_q, cmd_next_q, rw_q, hack_q;
  logic          scl_rise, scl_fall, start_det, stop_det, addr_hit;

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;
  assign addr_hit  = (rx_q[DW-1:1] == {ADDR_HI, strap_i});
  assign wr_data_o = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_IDLE;
      cnt_q       <= '0;
      rx_q        <= '0;
      tx_q        <= '0;
      is_addr_q   <= 1'b0;
      cmd_next_q  <= 1'b0;
      rw_q        <= 1'b0;
      hack_q      <= 1'b0;
      ptr_o       <= IDX_IN;
      wr_stb_o    <= 1'b0;
      snap_o      <= 1'b0;
      sda_drive_o <= 1'b0;
      rd_evt_o    <= 1'b0;
      stop_o      <= 1'b0;
    end else begin
      wr_stb_o <= 1'b0;
      snap_o   <= 1'b0;
      rd_evt_o <= 1'b0;
      stop_o   <= 1'b0;
      if (stop_det) begin
        phase_q     <= PH_IDLE;
        sda_drive_o <= 1'b0;
        stop_o      <= 1'b1;
      end else if (start_det) begin
        // any Start, even mid-byte, restarts address reception
        phase_q     <= PH_RX;
        cnt_q       <= '0;
        is_addr_q   <= 1'b1;
        cmd_next_q  <= 1'b1;
        rw_q        <= 1'b0;
        sda_drive_o <= 1'b0;
      end else begin
        unique case (phase_q)
          PH_RX: begin
            if (scl_rise && cnt_q != CNT_W'(DW)) begin
              rx_q  <= {rx_q[DW-2:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == CNT_W'(DW)) begin
              cnt_q <= '0;
              if (is_addr_q) begin
                is_addr_q <= 1'b0;
                if (addr_hit) begin
                  sda_drive_o <= 1'b1;
                  rw_q        <= rx_q[0];
                  phase_q     <= PH_SACK;
                end else begin
                  phase_q <= PH_IDLE;
                end
              end else begin
                sda_drive_o <= 1'b1;
                phase_q     <= PH_SACK;
                if (cmd_next_q) begin
                  cmd_next_q <= 1'b0;
                  ptr_o      <= rx_q[PTR_W-1:0];
                end else begin
                  wr_stb_o <= 1'b1;
                end
              end
            end
          end
          PH_SACK: begin
            if (scl_rise && rw_q) snap_o <= 1'b1;
            if (scl_fall) begin
              if (rw_q) begin
                tx_q        <= rd_data_i;
                sda_drive_o <= ~rd_data_i[DW-1];
                cnt_q       <= CNT_W'(1);
                phase_q     <= PH_TX;
              end else begin
                sda_drive_o <= 1'b0;
                phase_q     <= PH_RX;
              end
            end
          end
          PH_TX: begin
            if (scl_fall) begin
              if (cnt_q == CNT_W'(DW)) begin
                sda_drive_o <= 1'b0;
                phase_q     <= PH_HACK;
              end else begin
                sda_drive_o <= ~tx_q[DW-2];
                tx_q        <= {tx_q[DW-2:0], 1'b0};
                cnt_q       <= cnt_q + 1'b1;
              end
            end
          end
          PH_HACK: begin
            if (scl_rise) begin
              hack_q   <= ~sda_i;
              snap_o   <= 1'b1;
              rd_evt_o <= 1'b1;
            end
            if (scl_fall) begin
              if (hack_q) begin
                tx_q        <= rd_data_i;
                sda_drive_o <= ~rd_data_i[DW-1];
                cnt_q       <= CNT_W'(1);
                phase_q     <= PH_TX;
              end else begin
                phase_q <= PH_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target
  import i2cx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_TAPS   = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic [1:0]    strap_i,
  input  logic [DW-1:0] pin_i,
  output logic          sda_drive_o,
  output logic [DW-1:0] out_reg_o,
  output logic [DW-1:0] dir_o,
  output logic          rd_evt_o,
  output logic          stop_o
);
  localparam int unsigned N_LINES = 2;

  logic [N_LINES-1:0] raw_lines, flt_lines;
  logic [PTR_W-1:0]   ptr;
  logic               wr_stb, snap;
  logic [DW-1:0]      wr_data, rd_data;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_flt
    i2cx_line_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .TAPS       (FILT_TAPS)
    ) u_flt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw_lines[g]),
      .line_o(flt_lines[g])
    );
  end

  i2cx_bus_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (flt_lines[1]),
    .sda_i      (flt_lines[0]),
    .strap_i    (strap_i),
    .rd_data_i  (rd_data),
    .ptr_o      (ptr),
    .wr_stb_o   (wr_stb),
    .wr_data_o  (wr_data),
    .snap_o     (snap),
    .sda_drive_o(sda_drive_o),
    .rd_evt_o   (rd_evt_o),
    .stop_o     (stop_o)
  );

  i2cx_reg_bank #(.PIN_SYNC(SYNC_STAGES)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_stb_i (wr_stb),
    .sel_i    (ptr),
    .wr_data_i(wr_data),
    .snap_i   (snap),
    .pin_i    (pin_i),
    .rd_data_o(rd_data),
    .out_o    (out_reg_o),
    .dir_o    (dir_o)
  );
endmodule

// File: rtl/i2cx_chk.sv
module i2cx_chk
  import i2cx_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sda_drive_o,
  input logic [DW-1:0] out_reg_o,
  input logic [DW-1:0] dir_o,
  input logic          rd_evt_o,
  input logic          stop_o,
  input logic          wr_stb
);
  // R13
  stop_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_o |-> !sda_drive_o);

  // R13
  rd_evt_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_evt_o |=> !rd_evt_o);

  // R6
  hack_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_evt_o |-> !sda_drive_o);

  // R13
  evt_exclusive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rd_evt_o, stop_o}));

  // R7
  out_write_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(out_reg_o) |-> $past(wr_stb));

  // R3
  dir_write_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dir_o) |-> $past(wr_stb));
endmodule

bind i2c_regbank_target i2cx_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sda_drive_o(sda_drive_o),
  .out_reg_o  (out_reg_o),
  .dir_o      (dir_o),
  .rd_evt_o   (rd_evt_o),
  .stop_o     (stop_o),
  .wr_stb     (wr_stb)
);

// File: tb/i2c_regbank_target_bench.sv
module i2c_regbank_target_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam logic [7:0] AW = 8'hE4;  // strap 2'b10, write
  localparam logic [7:0] AR = 8'hE5;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       scl = 1'b1;
  logic       m_low = 1'b0;
  logic [7:0] pins = 8'h00;
  logic       sda_line, sda_drive, rd_evt, stop_p;
  logic [7:0] out_reg, dir;
  int         n_chk = 0, n_fail = 0, stop_cnt = 0, rd_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = !(m_low || sda_drive);

  i2c_regbank_target u_i2c_regbank_target (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl), .sda_i(sda_line),
    .strap_i(2'b10), .pin_i(pins), .sda_drive_o(sda_drive),
    .out_reg_o(out_reg), .dir_o(dir), .rd_evt_o(rd_evt), .stop_o(stop_p)
  );

  always @(negedge clk) begin
    if (stop_p) stop_cnt++;
    if (rd_evt) rd_cnt++;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_low = 1'b0; tick(Q); scl = 1'b1; tick(Q);
    m_low = 1'b1; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; tick(Q); scl = 1'b1; tick(Q);
    m_low = 1'b0; tick(2*Q);
  endtask

  task automatic wr_bit(logic b);
    m_low = !b; tick(Q); scl = 1'b1; tick(2*Q); scl = 1'b0; tick(Q);
  endtask

  task automatic rd_bit(output logic b);
    m_low = 1'b0; tick(Q); scl = 1'b1; tick(Q);
    b = sda_line; tick(Q); scl = 1'b0; tick(Q);
  endtask

  task automatic wr_byte(logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wr_bit(d[i]);
    rd_bit(b);
    ack = !b;
  endtask

  task automatic rd_byte(logic give_ack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) rd_bit(d[i]);
    wr_bit(!give_ack);
  endtask

  task automatic set_ptr(logic [7:0] cmd);
    logic a;
    bus_start(); wr_byte(AW, a); wr_byte(cmd, a);
  endtask

  task automatic read_one(logic [7:0] cmd, output logic [7:0] d);
    logic a;
    set_ptr(cmd); bus_start(); wr_byte(AR, a); rd_byte(1'b0, d); bus_stop();
  endtask

  task automatic t_reset();
    chk("R10 out", out_reg, 8'hFF);
    chk("R10 dir", dir, 8'hFF);
    chk("R10 sda", {7'd0, sda_drive}, 8'h00);
  endtask

  task automatic t_bad_addr();
    logic a;
    bus_start(); wr_byte(8'hE0, a);
    chk("R2 nack", {7'd0, a}, 8'h00);
    wr_byte(8'h01, a);
    chk("R2 silent", {7'd0, a}, 8'h00);
    bus_stop();
    chk("R2 out", out_reg, 8'hFF);
  endtask

  task automatic t_write_out();
    logic a; int s0;
    s0 = stop_cnt;
    bus_start(); wr_byte(AW, a);
    chk("R1 addr ack", {7'd0, a}, 8'h01);
    wr_byte(8'h01, a); wr_byte(8'h5A, a);
    chk("R4 data ack", {7'd0, a}, 8'h01);
    chk("R4 first", out_reg, 8'h5A);
    wr_byte(8'h3C, a);
    chk("R4 second same reg", out_reg, 8'h3C);
    bus_stop();
    chk("R13 stop pulse", 8'(stop_cnt - s0), 8'h01);
  endtask

  task automatic t_dir();
    logic a;
    set_ptr(8'h03); wr_byte(8'h0F, a); bus_stop();
    chk("R3 dir", dir, 8'h0F);
    chk("R3 out kept", out_reg, 8'h3C);
  endtask

  task automatic t_persist();
    logic a; logic [7:0] d;
    bus_start(); wr_byte(AR, a);
    rd_byte(1'b1, d); chk("R5 persist", d, 8'h0F);
    rd_byte(1'b0, d); chk("R6 repeat", d, 8'h0F);
    chk("R6 release", {7'd0, sda_drive}, 8'h00);
    bus_stop();
  endtask

  task automatic t_reg0_ignore();
    logic a; logic [7:0] d;
    set_ptr(8'h00); wr_byte(8'hAA, a); bus_stop();
    chk("R7 out", out_reg, 8'h3C);
    chk("R7 dir", dir, 8'h0F);
    read_one(8'h02, d);
    chk("R7 pol", d, 8'h00);
  endtask

  task automatic t_in_pol();
    logic a; logic [7:0] d;
    pins = 8'h35;
    read_one(8'h00, d); chk("R8 plain", d, 8'h35);
    set_ptr(8'h02); wr_byte(8'hF0, a); bus_stop();
    read_one(8'h00, d); chk("R8 inverted", d, 8'hC5);
  endtask

  task automatic t_out_read();
    logic [7:0] d;
    pins = 8'h00;
    read_one(8'h01, d); chk("R9 latched", d, 8'h3C);
  endtask

  task automatic t_snapshot();
    logic a; logic [7:0] d; int r0;
    pins = 8'h11;
    set_ptr(8'h00); bus_start(); wr_byte(AR, a);
    r0 = rd_cnt;
    pins = 8'h22;
    rd_byte(1'b1, d); chk("R11 first", d, 8'hE1);
    rd_byte(1'b0, d); chk("R11 second", d, 8'hD2);
    bus_stop();
    chk("R13 rd events", 8'(rd_cnt - r0), 8'h02);
  endtask

  task automatic t_abort();
    logic a;
    set_ptr(8'h01);
    wr_bit(1'b1); wr_bit(1'b0); wr_bit(1'b1); wr_bit(1'b0);
    bus_start();
    chk("R12 partial dropped", out_reg, 8'h3C);
    wr_byte(AW, a);
    chk("R12 resync ack", {7'd0, a}, 8'h01);
    wr_byte(8'h01, a); wr_byte(8'h81, a); bus_stop();
    chk("R12 write after", out_reg, 8'h81);
  endtask

  task automatic t_hw_reset();
    logic a; logic [7:0] d;
    rst_ni = 1'b0; tick(3);
    chk("R10 out", out_reg, 8'hFF);
    chk("R10 dir", dir, 8'hFF);
    rst_ni = 1'b1; pins = 8'h5C; tick(4);
    bus_start(); wr_byte(AR, a); rd_byte(1'b0, d); bus_stop();
    chk("R10 ptr and pol", d, 8'h5C);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(5); rst_ni = 1'b1; tick(5);
    t_reset();
    t_bad_addr();
    t_write_out();
    t_dir();
    t_persist();
    t_reg0_ignore();
    t_in_pol();
    t_out_read();
    t_snapshot();
    t_abort();
    t_hw_reset();
    finish_run();
  end
endmodule